// File: doc/BRIEF.md
# UART Interrupt Source Router

This block gathers the status events of a UART receiver and transmitter and merges them onto two interrupt lines, one for the receive side and one for the transmit side. A single mode input selects between a buffered (FIFO) arrangement and a direct single-register arrangement. The mode changes which events reach each line and which enable gates them.

The block holds four sticky receive error flags: break, framing, overrun and parity. Their OR forms an error summary. It also keeps a receive FIFO occupancy counter for up to 16 words, compared against a programmable 5-bit trigger level, and a sticky overflow flag. The transmit FIFO level condition is computed elsewhere and arrives as an input. Software reads the flags, clears them through strobes and sets the enables.

In direct mode, a break has its own receive path, shared with receive-ready. In FIFO mode, a break can only raise the receive line through the error summary.

Top module: `uart_irq_router`

## Requirements
- R1: Each error flag (break, framing, overrun, parity) is set on the cycle after its input pulse. It stays set until `err_clr` is sampled high. When a pulse and `err_clr` arrive in the same cycle, the flag is set.
- R2: `err_sum` is high exactly when at least one of the four error flags is set.
- R3: With `fifo_mode` low, `rx_irq` = (`en_rx_err` AND `err_sum`) OR (`en_rx_brk` AND (break flag OR `rx_ready`)).
- R4: With `fifo_mode` low, `tx_irq` = `en_tx` AND `tx_ready`. The `tx_lvl_hit` input and `en_tx_fifo` have no effect.
- R5: With `fifo_mode` high, `rx_irq` = (`en_rx_err` AND `err_sum`) OR (`en_rx_fifo` AND (`rx_lvl_hit` OR `rx_ovf`)). `rx_ready` and `en_rx_brk` have no effect, so a break reaches the line only through the error summary.
- R6: With `fifo_mode` high, `tx_irq` = `en_tx_fifo` AND `tx_lvl_hit`. `tx_ready` and `en_tx` have no effect.
- R7: `rx_count` responds to its controls as follows. It starts at 0 and never exceeds 16.
  - `rx_push` alone increments it.
  - `rx_pop` alone decrements it, with no change when it is 0.
  - Push and pop together leave it unchanged, except at 0, where it becomes 1.
  - `rx_flush` forces it to 0 on the next cycle, over push and pop.
  - A push at 16 without a pop leaves it at 16.
- R8: `rx_lvl_hit` is high exactly when `rx_count` >= `rx_trig`. This includes trigger 0 with an empty FIFO.
- R9: `rx_trig` resets to 31 (all ones) and takes `trig_din` on the cycle after `trig_wr`.
- R10: `rx_ovf` sets on the cycle after a push, without a pop, that arrives while `rx_count` is 16. It stays set until `ovf_clr`. A set and a clear in the same cycle leave it set.
- R11: After reset, all error flags, `rx_count`, `rx_ovf`, `rx_irq` and `tx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 selects FIFO routing, 0 selects direct routing |
| brk_pulse | input | 1 | Break detected event |
| fe_pulse | input | 1 | Framing error event |
| oe_pulse | input | 1 | Overrun error event |
| pe_pulse | input | 1 | Parity error event |
| err_clr | input | 1 | Clears all four error flags |
| rx_ready | input | 1 | Receive register holds a character (direct mode) |
| tx_ready | input | 1 | Transmit register empty (direct mode) |
| tx_lvl_hit | input | 1 | Transmit FIFO level condition (FIFO mode) |
| rx_push | input | 1 | A word enters the receive FIFO |
| rx_pop | input | 1 | A word leaves the receive FIFO |
| rx_flush | input | 1 | Reset receive occupancy to zero |
| ovf_clr | input | 1 | Clears the overflow flag |
| trig_wr | input | 1 | Load the receive trigger level |
| trig_din | input | 5 | New receive trigger level |
| en_rx_err | input | 1 | Error summary enable |
| en_rx_brk | input | 1 | Shared receive-ready / break enable (direct mode) |
| en_tx | input | 1 | Transmit-ready enable (direct mode) |
| en_rx_fifo | input | 1 | Receive FIFO enable (FIFO mode) |
| en_tx_fifo | input | 1 | Transmit FIFO enable (FIFO mode) |
| rx_irq | output | 1 | Receive interrupt line |
| tx_irq | output | 1 | Transmit interrupt line |
| brk_flag | output | 1 | Sticky break flag |
| fe_flag | output | 1 | Sticky framing error flag |
| oe_flag | output | 1 | Sticky overrun flag |
| pe_flag | output | 1 | Sticky parity flag |
| err_sum | output | 1 | OR of the four error flags |
| rx_count | output | 5 | Receive FIFO occupancy, 0 to 16 |
| rx_trig | output | 5 | Receive trigger level |
| rx_lvl_hit | output | 1 | Occupancy at or above the trigger |
| rx_ovf | output | 1 | Sticky receive overflow flag |

## Verification
A vector table sweeps both modes over combinations of enables and sources. Each entry pairs a live source with its enable turned off and a dead source with its enable turned on. This separates a correct mode switch from a swapped or unswitched one, in particular a break still reaching the line through the direct-mode enable while in FIFO mode. Directed sequences then drive the occupancy counter through increment, decrement, simultaneous push and pop, flush, pop on empty and push at full. The trigger is set to 0, 3 and 31, so that an off-by-one comparison or a missing saturation shows up. Same-cycle set and clear strobes on the error and overflow flags check the priority between the two.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ERR_N   = 4;
  localparam int ERR_BRK = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_OVR = 2;
  localparam int ERR_PAR = 3;

  typedef struct packed {
    logic err_sum;
    logic brk;
    logic rx_rdy;
    logic tx_rdy;
    logic rx_lvl;
    logic rx_ovf;
    logic tx_lvl;
  } irq_src_t;

  typedef struct packed {
    logic rx_err;
    logic rx_brk;
    logic tx;
    logic rx_fifo;
    logic tx_fifo;
  } irq_en_t;

  function automatic logic any_flag(input logic [ERR_N-1:0] f);
    return |f;
  endfunction
endpackage

// File: rtl/uart_err_flags.sv
module uart_err_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o,
  output logic         sum_o
);
  import uart_irq_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[i] <= 1'b0;
      else if (set_i[i])   flag_o[i] <= 1'b1;
      else if (clr_i)      flag_o[i] <= 1'b0;
    end

    assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    assert_flag_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[i] && !clr_i) |=> flag_o[i]);
    assert_flag_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i[i]) |=> !flag_o[i]);
    assert_sum_cover_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o[i] |-> sum_o);
  end

  if (N == ERR_N) begin : g_sum_pkg
    assign sum_o = any_flag(flag_o);
  end else begin : g_sum_generic
    assign sum_o = |flag_o;
  end

  assert_sum_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(flag_o) == 0) |-> !sum_o);
endmodule

// File: rtl/uart_rx_level.sv
module uart_rx_level #(
  parameter int DEPTH  = 16,
  parameter int TRIG_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMP_W = (CNT_W > TRIG_W) ? CNT_W : TRIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              flush_i,
  input  logic              ovf_clr_i,
  input  logic              trig_wr_i,
  input  logic [TRIG_W-1:0] trig_din_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [TRIG_W-1:0] trig_o,
  output logic              lvl_hit_o,
  output logic              ovf_o
);
  localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
  localparam logic [TRIG_W-1:0] TRIG_RST = {TRIG_W{1'b1}};

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic push, input logic pop, input logic flush);
    if (flush)                                 return '0;
    if (push && !pop && cur != FULL_CNT)       return cur + 1'b1;
    if (pop && !push && cur != '0)             return cur - 1'b1;
    if (push && pop && cur == '0)              return CNT_W'(1);
    return cur;
  endfunction

  function automatic logic lvl_reached(
    input logic [CNT_W-1:0] cnt, input logic [TRIG_W-1:0] trig);
    return CMP_W'(cnt) >= CMP_W'(trig);
  endfunction

  logic full_w;
  logic ovf_evt_w;
  assign full_w    = (count_o == FULL_CNT);
  assign ovf_evt_w = push_i && !pop_i && full_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= next_count(count_o, push_i, pop_i, flush_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         trig_o <= TRIG_RST;
    else if (trig_wr_i) trig_o <= trig_din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_o <= 1'b0;
    else if (ovf_evt_w) ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end

  assign lvl_hit_o = lvl_reached(count_o, trig_o);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= FULL_CNT);
  assert_push_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !flush_i && !full_w) |=> (count_o == $past(count_o) + 1'b1));
  assert_flush_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (count_o == '0));
  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_w && !flush_i) |=> full_w);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_w |=> ovf_o);
  assert_ovf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  assert_trig_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr_i |=> (trig_o == $past(trig_din_i)));
  assert_lvl_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_hit_o) |-> (!$stable(count_o) || !$stable(trig_o)));
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fifo_mode_i,
  input  irq_en_t  en_i,
  input  irq_src_t src_i,
  output logic     rx_irq_o,
  output logic     tx_irq_o
);
  logic err_path_w;
  logic rx_direct_w;
  logic rx_fifo_w;
  logic tx_direct_w;
  logic tx_fifo_w;

  assign err_path_w  = en_i.rx_err  & src_i.err_sum;
  assign rx_direct_w = en_i.rx_brk  & (src_i.brk | src_i.rx_rdy);
  assign rx_fifo_w   = en_i.rx_fifo & (src_i.rx_lvl | src_i.rx_ovf);
  assign tx_direct_w = en_i.tx      & src_i.tx_rdy;
  assign tx_fifo_w   = en_i.tx_fifo & src_i.tx_lvl;

  always_comb begin
    if (fifo_mode_i) begin
      rx_irq_o = err_path_w | rx_fifo_w;
      tx_irq_o = tx_fifo_w;
    end else begin
      rx_irq_o = err_path_w | rx_direct_w;
      tx_irq_o = tx_direct_w;
    end
  end

  assert_direct_rx_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode_i && !en_i.rx_err && !en_i.rx_brk) |-> !rx_irq_o);
  assert_direct_rx_brk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode_i && en_i.rx_brk && src_i.brk) |-> rx_irq_o);
  assert_direct_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode_i && !en_i.tx) |-> !tx_irq_o);
  assert_fifo_no_brk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode_i && !en_i.rx_err && !en_i.rx_fifo) |-> !rx_irq_o);
  assert_fifo_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode_i && en_i.rx_fifo && src_i.rx_ovf) |-> rx_irq_o);
  assert_fifo_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode_i && !en_i.tx_fifo) |-> !tx_irq_o);
endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router #(
  parameter int DEPTH  = 16,
  parameter int TRIG_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              brk_pulse,
  input  logic              fe_pulse,
  input  logic              oe_pulse,
  input  logic              pe_pulse,
  input  logic              err_clr,
  input  logic              rx_ready,
  input  logic              tx_ready,
  input  logic              tx_lvl_hit,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              rx_flush,
  input  logic              ovf_clr,
  input  logic              trig_wr,
  input  logic [TRIG_W-1:0] trig_din,
  input  logic              en_rx_err,
  input  logic              en_rx_brk,
  input  logic              en_tx,
  input  logic              en_rx_fifo,
  input  logic              en_tx_fifo,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              brk_flag,
  output logic              fe_flag,
  output logic              oe_flag,
  output logic              pe_flag,
  output logic              err_sum,
  output logic [CNT_W-1:0]  rx_count,
  output logic [TRIG_W-1:0] rx_trig,
  output logic              rx_lvl_hit,
  output logic              rx_ovf
);
  import uart_irq_pkg::*;

  logic [ERR_N-1:0] err_set_w;
  logic [ERR_N-1:0] err_flag_w;
  irq_en_t          en_w;
  irq_src_t         src_w;

  always_comb begin
    err_set_w          = '0;
    err_set_w[ERR_BRK] = brk_pulse;
    err_set_w[ERR_FRM] = fe_pulse;
    err_set_w[ERR_OVR] = oe_pulse;
    err_set_w[ERR_PAR] = pe_pulse;
  end

  uart_err_flags #(.N(ERR_N)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (err_set_w),
    .clr_i (err_clr),
    .flag_o(err_flag_w),
    .sum_o (err_sum)
  );

  assign brk_flag = err_flag_w[ERR_BRK];
  assign fe_flag  = err_flag_w[ERR_FRM];
  assign oe_flag  = err_flag_w[ERR_OVR];
  assign pe_flag  = err_flag_w[ERR_PAR];

  uart_rx_level #(.DEPTH(DEPTH), .TRIG_W(TRIG_W)) u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (rx_push),
    .pop_i     (rx_pop),
    .flush_i   (rx_flush),
    .ovf_clr_i (ovf_clr),
    .trig_wr_i (trig_wr),
    .trig_din_i(trig_din),
    .count_o   (rx_count),
    .trig_o    (rx_trig),
    .lvl_hit_o (rx_lvl_hit),
    .ovf_o     (rx_ovf)
  );

  assign en_w = '{rx_err: en_rx_err, rx_brk: en_rx_brk, tx: en_tx,
                  rx_fifo: en_rx_fifo, tx_fifo: en_tx_fifo};
  assign src_w = '{err_sum: err_sum, brk: brk_flag, rx_rdy: rx_ready, tx_rdy: tx_ready,
                   rx_lvl: rx_lvl_hit, rx_ovf: rx_ovf, tx_lvl: tx_lvl_hit};

  uart_irq_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_mode_i(fifo_mode),
    .en_i       (en_w),
    .src_i      (src_w),
    .rx_irq_o   (rx_irq),
    .tx_irq_o   (tx_irq)
  );

  assert_reset_idle_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> (rx_count == '0 && !rx_ovf && !err_sum));
endmodule

// File: tb/uart_irq_router_tb_top.sv
module uart_irq_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 0, brk_pulse = 0, fe_pulse = 0, oe_pulse = 0, pe_pulse = 0;
  logic err_clr = 0, rx_ready = 0, tx_ready = 0, tx_lvl_hit = 0;
  logic rx_push = 0, rx_pop = 0, rx_flush = 0, ovf_clr = 0, trig_wr = 0;
  logic [4:0] trig_din = '0;
  logic en_rx_err = 0, en_rx_brk = 0, en_tx = 0, en_rx_fifo = 0, en_tx_fifo = 0;
  logic rx_irq, tx_irq, brk_flag, fe_flag, oe_flag, pe_flag, err_sum, rx_lvl_hit, rx_ovf;
  logic [4:0] rx_count, rx_trig;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .brk_pulse(brk_pulse), .fe_pulse(fe_pulse), .oe_pulse(oe_pulse), .pe_pulse(pe_pulse),
    .err_clr(err_clr), .rx_ready(rx_ready), .tx_ready(tx_ready), .tx_lvl_hit(tx_lvl_hit),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_flush(rx_flush), .ovf_clr(ovf_clr),
    .trig_wr(trig_wr), .trig_din(trig_din),
    .en_rx_err(en_rx_err), .en_rx_brk(en_rx_brk), .en_tx(en_tx),
    .en_rx_fifo(en_rx_fifo), .en_tx_fifo(en_tx_fifo),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .brk_flag(brk_flag), .fe_flag(fe_flag),
    .oe_flag(oe_flag), .pe_flag(pe_flag), .err_sum(err_sum), .rx_count(rx_count),
    .rx_trig(rx_trig), .rx_lvl_hit(rx_lvl_hit), .rx_ovf(rx_ovf)
  );

  typedef struct packed {
    logic fifo, e_err, e_brk, e_tx, e_rfifo, e_tfifo;
    logic brk, fe, rxr, txr, tlvl;
    logic exp_rx, exp_tx;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{0,0,1,0,0,0, 0,0,1,0,0, 1,0},  // R3 receive-ready via shared enable
    '{0,0,1,0,0,0, 1,0,0,0,0, 1,0},  // R3 break via shared enable
    '{0,1,0,0,0,0, 0,1,0,0,0, 1,0},  // R3 error summary path
    '{0,0,0,0,1,1, 1,1,1,0,1, 0,0},  // R3 FIFO enables ignored in direct mode
    '{0,0,0,1,0,1, 0,0,0,1,1, 0,1},  // R4 transmit-ready routed
    '{0,0,0,0,0,1, 0,0,0,1,1, 0,0},  // R4 FIFO level ignored
    '{1,0,1,0,0,0, 1,0,1,0,0, 0,0},  // R5 break has no own path
    '{1,1,0,0,0,0, 1,0,0,0,0, 1,0},  // R5 break via error summary
    '{1,0,0,0,0,1, 0,0,0,0,1, 0,1},  // R6 transmit level routed
    '{1,0,0,1,0,0, 0,0,0,1,0, 0,0},  // R6 direct tx enable ignored
    '{1,0,0,1,0,1, 0,0,0,1,0, 0,0},  // R6 level low keeps line low
    '{1,0,0,0,1,0, 0,0,1,0,0, 0,0}   // R5 rx_ready ignored, level below trigger 31
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_ctrl();
    {brk_pulse, fe_pulse, oe_pulse, pe_pulse, err_clr} = '0;
    {rx_push, rx_pop, rx_flush, ovf_clr, trig_wr} = '0;
  endtask

  task automatic set_trig(input logic [4:0] v);
    trig_din = v; trig_wr = 1; tick(); trig_wr = 0;
  endtask

  task automatic push_n(input int n);
    for (int k = 0; k < n; k++) begin rx_push = 1; tick(); end
    rx_push = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R11 reset state
    chk("R11 rx_count", rx_count, 0);
    chk("R11 flags", {brk_flag, fe_flag, oe_flag, pe_flag, err_sum, rx_ovf}, 0);
    chk("R11 irq lines", {rx_irq, tx_irq}, 0);
    chk("R9 trigger reset", rx_trig, 31);

    for (int v = 0; v < NV; v++) begin
      {fifo_mode, en_rx_err, en_rx_brk, en_tx, en_rx_fifo, en_tx_fifo} = '0;
      {rx_ready, tx_ready, tx_lvl_hit} = '0;
      err_clr = 1; tick(); err_clr = 0;
      brk_pulse = VECS[v].brk; fe_pulse = VECS[v].fe; tick();
      brk_pulse = 0; fe_pulse = 0;
      fifo_mode = VECS[v].fifo; en_rx_err = VECS[v].e_err; en_rx_brk = VECS[v].e_brk;
      en_tx = VECS[v].e_tx; en_rx_fifo = VECS[v].e_rfifo; en_tx_fifo = VECS[v].e_tfifo;
      rx_ready = VECS[v].rxr; tx_ready = VECS[v].txr; tx_lvl_hit = VECS[v].tlvl;
      tick();
      chk($sformatf("R3/R5 rx_irq vector %0d", v), rx_irq, VECS[v].exp_rx);
      chk($sformatf("R4/R6 tx_irq vector %0d", v), tx_irq, VECS[v].exp_tx);
      chk($sformatf("R2 err_sum vector %0d", v), err_sum, VECS[v].brk | VECS[v].fe);
    end

    {fifo_mode, en_rx_err, en_rx_brk, en_tx, en_rx_fifo, en_tx_fifo} = 6'b100000;
    {rx_ready, tx_ready, tx_lvl_hit} = '0;
    err_clr = 1; tick(); err_clr = 0;

    // R1: each flag alone, then clear
    for (int i = 0; i < 4; i++) begin
      brk_pulse = (i == 0); fe_pulse = (i == 1); oe_pulse = (i == 2); pe_pulse = (i == 3);
      tick(); clear_ctrl(); tick();
      chk("R1 single flag set", {pe_flag, oe_flag, fe_flag, brk_flag}, 1 << i);
      chk("R2 summary from one flag", err_sum, 1);
      err_clr = 1; tick(); err_clr = 0;
      chk("R1 flag cleared", {pe_flag, oe_flag, fe_flag, brk_flag, err_sum}, 0);
    end
    pe_pulse = 1; err_clr = 1; tick(); clear_ctrl();
    chk("R1 set wins over clear", pe_flag, 1);
    err_clr = 1; tick(); err_clr = 0;

    // R7/R8/R9 occupancy and trigger
    push_n(3);
    chk("R7 three pushes", rx_count, 3);
    chk("R8 below trigger 31", rx_lvl_hit, 0);
    set_trig(5'd3);
    chk("R9 trigger written", rx_trig, 3);
    chk("R8 count equals trigger", rx_lvl_hit, 1);
    en_rx_fifo = 1; #1;
    chk("R5 level routed", rx_irq, 1);
    rx_pop = 1; tick(); rx_pop = 0;
    chk("R7 pop decrements", rx_count, 2);
    chk("R8 below trigger", rx_lvl_hit, 0);
    chk("R5 line drops below level", rx_irq, 0);
    rx_push = 1; rx_pop = 1; tick(); clear_ctrl();
    chk("R7 push and pop hold", rx_count, 2);
    rx_flush = 1; rx_push = 1; tick(); clear_ctrl();
    chk("R7 flush wins", rx_count, 0);
    rx_pop = 1; tick(); clear_ctrl();
    chk("R7 pop on empty", rx_count, 0);
    rx_push = 1; rx_pop = 1; tick(); clear_ctrl();
    chk("R7 push and pop on empty", rx_count, 1);
    rx_flush = 1; tick(); clear_ctrl();
    set_trig(5'd0);
    chk("R8 trigger zero at empty", rx_lvl_hit, 1);

    // R10 overflow
    set_trig(5'd31);
    push_n(16);
    chk("R7 full count", rx_count, 16);
    chk("R10 no overflow at full", rx_ovf, 0);
    chk("R5 idle at full, trigger 31", rx_irq, 0);
    rx_push = 1; rx_pop = 1; tick(); clear_ctrl();
    chk("R10 push with pop at full", rx_ovf, 0);
    chk("R7 push with pop at full", rx_count, 16);
    rx_push = 1; tick(); clear_ctrl();
    chk("R10 overflow set", rx_ovf, 1);
    chk("R7 saturates at 16", rx_count, 16);
    chk("R5 overflow routed", rx_irq, 1);
    tick();
    chk("R10 overflow sticky", rx_ovf, 1);
    ovf_clr = 1; tick(); clear_ctrl();
    chk("R10 overflow cleared", rx_ovf, 0);
    rx_push = 1; ovf_clr = 1; tick(); clear_ctrl();
    chk("R10 set wins over clear", rx_ovf, 1);
    fifo_mode = 0; en_rx_brk = 0; #1;
    chk("R3 overflow ignored in direct mode", rx_irq, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule